// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a parameterized register of `WIDTH` bits, all updated together on the rising clock edge. A two-bit mode input picks one action per edge: keep the stored value, shift toward the low end, shift toward the high end, or load the whole word in parallel. Each shift direction has its own serial input. Each direction also has its own serial output, taken from the bit that leaves the register in that direction.

An active-low asynchronous clear forces every bit to zero and overrides every mode. The stored word is driven on the parallel outputs at all times. The block fits serial-to-parallel and parallel-to-serial conversion, and any datapath that needs a register able to move in both directions.

Top module: `ushift_reg`

## Requirements
- R1: While `clr_n` is low the stored word is all zeros, and the outputs go to zero without waiting for a clock edge.
- R2: Mode 2'b00 (hold) keeps the stored word unchanged across the clock edge.
- R3: Mode 2'b01 (shift right): the new bit WIDTH-1 is `ser_in_r`, and the new bit i is the old bit i+1 for i < WIDTH-1.
- R4: Mode 2'b10 (shift left): the new bit 0 is `ser_in_l`, and the new bit i is the old bit i-1 for i > 0.
- R5: Mode 2'b11 (parallel load) stores `par_in` on the clock edge.
- R6: `ser_out_r` always equals bit 0 of the stored word, and `ser_out_l` always equals bit WIDTH-1.
- R7: `par_out` always shows the stored word, and all bits change on the same clock edge.
- R8: Clear has priority: while `clr_n` is low, no mode changes the stored word away from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_in_r | input | 1 | Serial input for the right shift, enters the MSB |
| ser_in_l | input | 1 | Serial input for the left shift, enters the LSB |
| par_in | input | WIDTH | Parallel load data |
| par_out | output | WIDTH | Stored word |
| ser_out_r | output | 1 | Bit 0, the bit a right shift pushes out |
| ser_out_l | output | 1 | Bit WIDTH-1, the bit a left shift pushes out |

## Verification
A wrong bit-selector choice shows on `par_out` on the very edge on which that mode is used, because nothing sits between the flops and the port. A fault that swaps the shift directions or the serial inputs shows in the first shift cycle, either on the serial outputs or in the entering bit. A clear that is handled synchronously instead of asynchronously shows as nonzero outputs between the fall of `clr_n` and the next edge. The bench therefore samples during that interval.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD  = 2'b00,
      MODE_SHR   = 2'b01,
      MODE_SHL   = 2'b10,
      MODE_LOAD  = 2'b11
   } ushift_mode_e;
endpackage

// File: rtl/ushift_bit_sel.sv
module ushift_bit_sel
   import ushift_pkg::*;
(
   input  ushift_mode_e mode,
   input  logic         cur_bit,
   input  logic         from_high,
   input  logic         from_low,
   input  logic         load_bit,
   output logic         nxt_bit
);
   always_comb begin
      unique case (mode)
         MODE_HOLD: nxt_bit = cur_bit;
         MODE_SHR:  nxt_bit = from_high;
         MODE_SHL:  nxt_bit = from_low;
         default:   nxt_bit = load_bit;
      endcase
   end
endmodule

// File: rtl/ushift_store.sv
module ushift_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
   import ushift_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [1:0]       mode,
   input  logic             ser_in_r,
   input  logic             ser_in_l,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] par_out,
   output logic             ser_out_r,
   output logic             ser_out_l
);
   localparam int MSB = WIDTH - 1;

   initial begin
      assert (WIDTH >= 2) else $error("ushift_reg: WIDTH must be at least 2");
   end

   ushift_mode_e     mode_e;
   logic [WIDTH-1:0] cur_q;
   logic [WIDTH-1:0] nxt_q;

   assign mode_e = ushift_mode_e'(mode);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic hi_src;
      logic lo_src;
      if (i == MSB) begin : g_top
         assign hi_src = ser_in_r;
      end else begin : g_mid_hi
         assign hi_src = cur_q[i+1];
      end
      if (i == 0) begin : g_bot
         assign lo_src = ser_in_l;
      end else begin : g_mid_lo
         assign lo_src = cur_q[i-1];
      end
      ushift_bit_sel sel_i (
         .mode      (mode_e),
         .cur_bit   (cur_q[i]),
         .from_high (hi_src),
         .from_low  (lo_src),
         .load_bit  (par_in[i]),
         .nxt_bit   (nxt_q[i])
      );
   end

   ushift_store #(.WIDTH(WIDTH)) store_i (
      .clk   (clk),
      .clr_n (clr_n),
      .d     (nxt_q),
      .q     (cur_q)
   );

   assign par_out   = cur_q;
   assign ser_out_r = cur_q[0];
   assign ser_out_l = cur_q[MSB];

   assert_clear_zero_R1: assert property (@(posedge clk) !clr_n |-> par_out == '0);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
      mode == 2'b00 |=> $stable(par_out));

   assert_shr_R3: assert property (@(posedge clk) disable iff (!clr_n)
      mode == 2'b01 |=> par_out == {$past(ser_in_r), $past(par_out[MSB:1])});

   assert_shl_R4: assert property (@(posedge clk) disable iff (!clr_n)
      mode == 2'b10 |=> par_out == {$past(par_out[MSB-1:0]), $past(ser_in_l)});

   assert_load_R5: assert property (@(posedge clk) disable iff (!clr_n)
      mode == 2'b11 |=> par_out == $past(par_in));

   always_comb begin
      assert_serout_R6: assert (ser_out_r == par_out[0] && ser_out_l == par_out[MSB]);
   end
endmodule

// File: tb/ushift_reg_tb_top.sv
module ushift_reg_tb_top;
   localparam int W = 8;
   logic clk = 0;
   logic clr_n = 0;
   logic [1:0] mode = 2'b00;
   logic sir = 0, sil = 0;
   logic [W-1:0] pin = '0;
   logic [W-1:0] pout;
   logic sor, sol;
   int checks = 0, fails = 0;
   logic [W-1:0] model;

   always #2 clk = ~clk;

   ushift_reg #(.WIDTH(W)) dut_i (
      .clk(clk), .clr_n(clr_n), .mode(mode), .ser_in_r(sir), .ser_in_l(sil),
      .par_in(pin), .par_out(pout), .ser_out_r(sor), .ser_out_l(sol)
   );

   task automatic chk(string req, logic [W-1:0] exp);
      checks++;
      if (pout !== exp || sor !== exp[0] || sol !== exp[W-1]) begin
         fails++;
         $display("FAIL %s: par_out=%h sor=%b sol=%b expected %h", req, pout, sor, sol, exp);
      end
   endtask

   task automatic step(logic [1:0] m, logic r, logic l, logic [W-1:0] d);
      @(negedge clk);
      mode = m; sir = r; sil = l; pin = d;
      @(posedge clk);
      case (m)
         2'b01: model = {r, model[W-1:1]};
         2'b10: model = {model[W-2:0], l};
         2'b11: model = d;
         default: ;
      endcase
      #1;
   endtask

   task automatic t_reset;
      #1 chk("R1", '0);
      @(negedge clk) clr_n = 1; model = '0;
      #1 chk("R1", '0);
   endtask

   task automatic t_load;
      step(2'b11, 0, 0, 8'hA5); chk("R5", model);
      step(2'b11, 1, 1, 8'h3C); chk("R5 R7", 8'h3C);
   endtask

   task automatic t_hold;
      step(2'b00, 1, 1, 8'hFF); chk("R2", 8'h3C);
      step(2'b00, 0, 0, 8'h00); chk("R2", 8'h3C);
   endtask

   task automatic t_shr;
      step(2'b01, 1, 0, 8'h00); chk("R3", 8'h9E);
      step(2'b01, 0, 1, 8'hFF); chk("R3", 8'h4F);
      for (int k = 0; k < 3; k++) begin
         step(2'b01, 1, 0, 8'h00); chk("R3 R6", model);
      end
   endtask

   task automatic t_shl;
      step(2'b11, 0, 0, 8'h81); chk("R5", 8'h81);
      step(2'b10, 0, 1, 8'h00); chk("R4", 8'h03);
      step(2'b10, 1, 0, 8'hFF); chk("R4 R6", 8'h06);
      for (int k = 0; k < 4; k++) begin
         step(2'b10, 0, k[0], 8'h00); chk("R4", model);
      end
   endtask

   task automatic t_clear_async;
      step(2'b11, 0, 0, 8'hFF); chk("R5", 8'hFF);
      @(posedge clk); #1;
      clr_n = 0; mode = 2'b11; pin = 8'h77;
      #0.5 chk("R1", '0);
      @(posedge clk); #1 chk("R8", '0);
      mode = 2'b01; sir = 1;
      @(posedge clk); #1 chk("R8", '0);
      @(negedge clk) clr_n = 1; mode = 2'b00; model = '0;
      #1 chk("R8", '0);
   endtask

   initial begin
      fork
         begin
            t_reset; t_load; t_hold; t_shr; t_shl; t_clear_async;
         end
         begin
            repeat (5000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule